// File: doc/BRIEF.md
# Split-Halfword Instruction Fetch Unit

This block fetches a single instruction from virtually addressed memory. It handles a mix of 16-bit and 32-bit instruction lengths. A fetch starts with a virtual address. The block first checks the address alignment. It then asks an external translator for the physical address of the low halfword and reads those 16 bits from a halfword-wide memory port. From the two lowest bits of that halfword it decides whether the instruction is compressed.

A full-length instruction needs its upper halfword. The block sends the address two bytes higher to the translator as a separate request and reads the halfword found there. The two halves are then joined. Because the two halves are translated independently, a 32-bit instruction may cross a page boundary and land on two unrelated physical pages.

A build-time switch can turn off compressed support. In that build, alignment is on four bytes. A single translation then covers the whole word, which is read as two consecutive halfwords. Every fetch ends with a one-cycle completion pulse. The pulse carries either the instruction or a fault code together with the virtual address that caused the fault.

Top module: `halfword_fetch_unit`

## Requirements
- R1: After reset the unit reports ready, holds done low and asserts neither the translation request nor the memory request.
- R2: A start address is misaligned when bit 0 is set (compressed support on) or when either of bits 1:0 is set (compressed support off). A misaligned start completes in the next cycle with fault code 2'b01 and the start address as fault address, and no translation is requested.
- R3: The low halfword's virtual address is sent to the translator first, with the fetch flag at 1. The request and its address are held until the response arrives, and the 16 bits are then read at the returned physical address.
- R4: With compressed support on, a low halfword whose bits 1:0 are not 2'b11 ends the fetch after one translation, with instruction bits 31:16 equal to zero.
- R5: With compressed support on, a low halfword whose bits 1:0 are 2'b11 causes a second translation of start address + 2. The halfword at its physical address is read, and the result is {high halfword, low halfword}, also when the two halves lie on different pages.
- R6: A translation fault on either halfword ends the fetch with fault code 2'b10, the virtual address of the faulting halfword as fault address and an all-zero instruction. No further memory read is made for that fetch.
- R7: With compressed support off, exactly one translation is made. The halfwords at the physical address and the physical address + 2 are read and joined as {upper, lower}, whatever the low bits of the lower halfword.
- R8: done is a single-cycle pulse. ready is low from the cycle after a start until the done cycle inclusive, and a start pulse seen while not ready has no effect.
- R9: The translation request and the memory request are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch (taken only when ready) |
| start_vaddr_i | input | VA_W | Virtual address of the instruction |
| ready_o | output | 1 | Unit idle, a start will be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| insn_o | output | 32 | Fetched instruction (zero on a fault) |
| fault_code_o | output | 2 | 00 none, 01 misaligned, 10 access fault |
| fault_vaddr_o | output | VA_W | Virtual address that faulted |
| xl_req_o | output | 1 | Translation request, held until response |
| xl_vaddr_o | output | VA_W | Virtual address to translate |
| xl_fetch_o | output | 1 | Marks the access as an instruction fetch |
| xl_rsp_i | input | 1 | Translation response strobe |
| xl_paddr_i | input | PA_W | Translated physical address |
| xl_fault_i | input | 1 | Translation failed |
| mem_req_o | output | 1 | Halfword read request, held until data |
| mem_addr_o | output | PA_W | Physical halfword address |
| mem_rvalid_i | input | 1 | Read data strobe |
| mem_rdata_i | input | 16 | Read halfword |

## Verification
The hardest case to reach from the ports is a full-length instruction whose second halfword sits on another page. It matters most when that second translation faults after the first has succeeded. The bench's translator model flips page-number bits, so consecutive virtual pages map to physical pages that are not adjacent. A memory override table then puts a 2'b11 low halfword at the last offset of a page. Placed in front of a page that always faults, the same setup yields the late fault. Varying the response latency keeps the held-request behaviour under test.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int HW_W   = 16;
    localparam int INSN_W = 2 * HW_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE_LO,
        ST_READ_LO,
        ST_XLATE_HI,
        ST_READ_HI,
        ST_DONE
    } fetch_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'b00,
        FC_MISALIGN = 2'b01,
        FC_ACCESS   = 2'b10
    } fetch_fault_e;

endpackage

// File: rtl/fetch_align_chk.sv
module fetch_align_chk #(
    parameter bit COMP_EN = 1'b1
) (
    input  logic [1:0] addr_lsb_i,
    output logic       misaligned_o
);
    localparam logic WORD_ONLY = ~COMP_EN;

    always_comb begin
        misaligned_o = addr_lsb_i[0] | (addr_lsb_i[1] & WORD_ONLY);
    end
endmodule

// File: rtl/fetch_len_decode.sv
module fetch_len_decode #(
    parameter bit COMP_EN = 1'b1
) (
    input  logic [1:0] op_lsb_i,
    output logic       is_short_o
);
    always_comb begin
        is_short_o = COMP_EN & (op_lsb_i != 2'b11);
    end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter bit COMP_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [VA_W-1:0]     start_vaddr_i,
    input  logic                misaligned_i,
    input  logic                is_short_i,
    output logic                ready_o,
    output logic                done_o,
    output logic [INSN_W-1:0]   insn_o,
    output logic [1:0]          fault_code_o,
    output logic [VA_W-1:0]     fault_vaddr_o,
    output logic                xl_req_o,
    output logic [VA_W-1:0]     xl_vaddr_o,
    output logic                xl_fetch_o,
    input  logic                xl_rsp_i,
    input  logic [PA_W-1:0]     xl_paddr_i,
    input  logic                xl_fault_i,
    output logic                mem_req_o,
    output logic [PA_W-1:0]     mem_addr_o,
    input  logic                mem_rvalid_i,
    input  logic [HW_W-1:0]     mem_rdata_i
);
    localparam logic [VA_W-1:0] VA_STEP = VA_W'(HW_W / 8);
    localparam logic [PA_W-1:0] PA_STEP = PA_W'(HW_W / 8);
    localparam bit              SPLIT   = COMP_EN;

    typedef struct packed {
        fetch_state_e     state;
        logic [VA_W-1:0]  xva;
        logic [PA_W-1:0]  paddr;
        logic [HW_W-1:0]  lo;
        logic [HW_W-1:0]  hi;
        fetch_fault_e     code;
        logic [VA_W-1:0]  fva;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.xva   = start_vaddr_i;
                    ctrl_d.lo    = '0;
                    ctrl_d.hi    = '0;
                    ctrl_d.code  = FC_NONE;
                    ctrl_d.fva   = '0;
                    if (misaligned_i) begin
                        ctrl_d.code  = FC_MISALIGN;
                        ctrl_d.fva   = start_vaddr_i;
                        ctrl_d.state = ST_DONE;
                    end else begin
                        ctrl_d.state = ST_XLATE_LO;
                    end
                end
            end
            ST_XLATE_LO, ST_XLATE_HI: begin
                if (xl_rsp_i) begin
                    if (xl_fault_i) begin
                        ctrl_d.code  = FC_ACCESS;
                        ctrl_d.fva   = ctrl_q.xva;
                        ctrl_d.state = ST_DONE;
                    end else begin
                        ctrl_d.paddr = xl_paddr_i;
                        ctrl_d.state = (ctrl_q.state == ST_XLATE_LO) ? ST_READ_LO : ST_READ_HI;
                    end
                end
            end
            ST_READ_LO: begin
                if (mem_rvalid_i) begin
                    ctrl_d.lo = mem_rdata_i;
                    if (is_short_i) begin
                        ctrl_d.state = ST_DONE;
                    end else if (SPLIT) begin
                        ctrl_d.xva   = ctrl_q.xva + VA_STEP;
                        ctrl_d.state = ST_XLATE_HI;
                    end else begin
                        ctrl_d.paddr = ctrl_q.paddr + PA_STEP;
                        ctrl_d.state = ST_READ_HI;
                    end
                end
            end
            ST_READ_HI: begin
                if (mem_rvalid_i) begin
                    ctrl_d.hi    = mem_rdata_i;
                    ctrl_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, code: FC_NONE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        ready_o       = (ctrl_q.state == ST_IDLE);
        done_o        = (ctrl_q.state == ST_DONE);
        insn_o        = (ctrl_q.code == FC_NONE) ? {ctrl_q.hi, ctrl_q.lo} : '0;
        fault_code_o  = ctrl_q.code;
        fault_vaddr_o = ctrl_q.fva;
        xl_req_o      = (ctrl_q.state == ST_XLATE_LO) || (ctrl_q.state == ST_XLATE_HI);
        xl_vaddr_o    = ctrl_q.xva;
        xl_fetch_o    = 1'b1;
        mem_req_o     = (ctrl_q.state == ST_READ_LO) || (ctrl_q.state == ST_READ_HI);
        mem_addr_o    = ctrl_q.paddr;
    end
endmodule

// File: rtl/halfword_fetch_unit.sv
module halfword_fetch_unit
    import fetch_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter bit COMP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VA_W-1:0]   start_vaddr_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [31:0]       insn_o,
    output logic [1:0]        fault_code_o,
    output logic [VA_W-1:0]   fault_vaddr_o,
    output logic              xl_req_o,
    output logic [VA_W-1:0]   xl_vaddr_o,
    output logic              xl_fetch_o,
    input  logic              xl_rsp_i,
    input  logic [PA_W-1:0]   xl_paddr_i,
    input  logic              xl_fault_i,
    output logic              mem_req_o,
    output logic [PA_W-1:0]   mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [15:0]       mem_rdata_i
);
    logic misaligned;
    logic is_short;

    fetch_align_chk #(.COMP_EN(COMP_EN)) u_align (
        .addr_lsb_i   (start_vaddr_i[1:0]),
        .misaligned_o (misaligned)
    );

    fetch_len_decode #(.COMP_EN(COMP_EN)) u_len (
        .op_lsb_i   (mem_rdata_i[1:0]),
        .is_short_o (is_short)
    );

    fetch_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .COMP_EN(COMP_EN)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_vaddr_i (start_vaddr_i),
        .misaligned_i  (misaligned),
        .is_short_i    (is_short),
        .ready_o       (ready_o),
        .done_o        (done_o),
        .insn_o        (insn_o),
        .fault_code_o  (fault_code_o),
        .fault_vaddr_o (fault_vaddr_o),
        .xl_req_o      (xl_req_o),
        .xl_vaddr_o    (xl_vaddr_o),
        .xl_fetch_o    (xl_fetch_o),
        .xl_rsp_i      (xl_rsp_i),
        .xl_paddr_i    (xl_paddr_i),
        .xl_fault_i    (xl_fault_i),
        .mem_req_o     (mem_req_o),
        .mem_addr_o    (mem_addr_o),
        .mem_rvalid_i  (mem_rvalid_i),
        .mem_rdata_i   (mem_rdata_i)
    );
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
    parameter int VA_W    = 32,
    parameter bit COMP_EN = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      start_lsb_i,
    input logic            ready_o,
    input logic            done_o,
    input logic [31:0]     insn_o,
    input logic [1:0]      fault_code_o,
    input logic            xl_req_o,
    input logic [VA_W-1:0] xl_vaddr_o,
    input logic            xl_rsp_i,
    input logic            mem_req_o
);
    logic bad_lsb;
    assign bad_lsb = COMP_EN ? start_lsb_i[0] : (start_lsb_i != 2'b00);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (ready_o && !xl_req_o && !mem_req_o));

    assert_misalign_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && bad_lsb) |=> (done_o && fault_code_o == 2'b01 && !xl_req_o));

    assert_xl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_o && !xl_rsp_i) |=> (xl_req_o && $stable(xl_vaddr_o)));

    assert_short_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (COMP_EN && done_o && fault_code_o == 2'b00 && insn_o[1:0] != 2'b11) |-> (insn_o[31:16] == 16'h0000));

    assert_fault_zero_insn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_code_o != 2'b00) |-> (insn_o == 32'h0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ready_o);

    assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req_o && mem_req_o));
endmodule

bind halfword_fetch_unit fetch_unit_chk #(.VA_W(VA_W), .COMP_EN(COMP_EN)) u_fetch_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_lsb_i  (start_vaddr_i[1:0]),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .insn_o       (insn_o),
    .fault_code_o (fault_code_o),
    .xl_req_o     (xl_req_o),
    .xl_vaddr_o   (xl_vaddr_o),
    .xl_rsp_i     (xl_rsp_i),
    .mem_req_o    (mem_req_o)
);

// File: tb/test_halfword_fetch_unit.sv
`timescale 1ns/1ps
module test_halfword_fetch_unit;

    typedef struct {
        logic [31:0] insn;
        logic [1:0]  code;
        logic [31:0] fva;
        int          nxl;
        bit          word_mode;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start0 = 1'b0, start1 = 1'b0;
    logic [31:0] va = '0;
    logic        ready0, ready1, done0, done1;
    logic [31:0] insn0, insn1, fva0, fva1;
    logic [1:0]  code0, code1;
    logic        xreq0, xreq1, xf0, xf1, mreq0, mreq1;
    logic [31:0] xva0, xva1, maddr0, maddr1;
    logic        xl_rsp = 1'b0, xl_fault = 1'b0;
    logic [31:0] xl_paddr = '0;
    logic        mem_rv = 1'b0;
    logic [15:0] mem_rd = '0;

    int checks = 0, errors = 0;
    int nxl = 0, lat = 0, xl_cnt = 0, mem_cnt = 0;
    exp_t exp_q[$];
    logic [15:0] ovr [logic [31:0]];

    always #5 clk = ~clk;

    halfword_fetch_unit #(.COMP_EN(1'b1)) i_halfword_fetch_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start0), .start_vaddr_i(va),
        .ready_o(ready0), .done_o(done0), .insn_o(insn0), .fault_code_o(code0),
        .fault_vaddr_o(fva0), .xl_req_o(xreq0), .xl_vaddr_o(xva0), .xl_fetch_o(xf0),
        .xl_rsp_i(xl_rsp), .xl_paddr_i(xl_paddr), .xl_fault_i(xl_fault),
        .mem_req_o(mreq0), .mem_addr_o(maddr0), .mem_rvalid_i(mem_rv), .mem_rdata_i(mem_rd));

    halfword_fetch_unit #(.COMP_EN(1'b0)) i_halfword_fetch_unit_word (
        .clk(clk), .rst_n(rst_n), .start_i(start1), .start_vaddr_i(va),
        .ready_o(ready1), .done_o(done1), .insn_o(insn1), .fault_code_o(code1),
        .fault_vaddr_o(fva1), .xl_req_o(xreq1), .xl_vaddr_o(xva1), .xl_fetch_o(xf1),
        .xl_rsp_i(xl_rsp), .xl_paddr_i(xl_paddr), .xl_fault_i(xl_fault),
        .mem_req_o(mreq1), .mem_addr_o(maddr1), .mem_rvalid_i(mem_rv), .mem_rdata_i(mem_rd));

    // translator model: page 5 faults, page number bits are scrambled
    function automatic bit tr_fault(logic [31:0] a);
        return a[31:12] == 20'h00005;
    endfunction
    function automatic logic [31:0] tr_pa(logic [31:0] a);
        return a ^ 32'h0003_7000;
    endfunction
    function automatic logic [15:0] hw(logic [31:0] pa);
        if (ovr.exists(pa)) return ovr[pa];
        return 16'h5A00 ^ pa[15:0];
    endfunction

    function automatic exp_t model(bit wm, logic [31:0] a, string req);
        exp_t e;
        logic [15:0] lo;
        e.insn = '0; e.code = 2'b00; e.fva = '0; e.nxl = 0; e.word_mode = wm; e.req = req;
        if (wm ? (a[1:0] != 2'b00) : a[0]) begin
            e.code = 2'b01; e.fva = a; return e;
        end
        e.nxl = 1;
        if (tr_fault(a)) begin e.code = 2'b10; e.fva = a; return e; end
        lo = hw(tr_pa(a));
        if (wm) begin e.insn = {hw(tr_pa(a) + 32'd2), lo}; return e; end
        if (lo[1:0] != 2'b11) begin e.insn = {16'h0000, lo}; return e; end
        e.nxl = 2;
        if (tr_fault(a + 32'd2)) begin e.code = 2'b10; e.fva = a + 32'd2; return e; end
        e.insn = {hw(tr_pa(a + 32'd2)), lo};
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // translation responder (shared; only the active instance requests)
    logic        xl_req_any;
    logic [31:0] xl_va_any;
    logic        xl_fetch_any;
    logic        mem_req_any;
    logic [31:0] mem_addr_any;
    assign xl_req_any   = xreq0 | xreq1;
    assign xl_va_any    = xreq1 ? xva1 : xva0;
    assign xl_fetch_any = xreq1 ? xf1 : xf0;
    assign mem_req_any  = mreq0 | mreq1;
    assign mem_addr_any = mreq1 ? maddr1 : maddr0;

    always @(negedge clk) begin
        if (xl_rsp) begin
            xl_rsp = 1'b0; xl_fault = 1'b0;
        end else if (xl_req_any) begin
            if (xl_cnt <= 0) begin
                xl_rsp = 1'b1;
                xl_fault = tr_fault(xl_va_any);
                xl_paddr = tr_pa(xl_va_any);
                nxl++;
                xl_cnt = lat;
                chk(xl_fetch_any == 1'b1, "R3", "fetch flag", {31'h0, xl_fetch_any}, 32'h1);
            end else xl_cnt--;
        end
    end

    always @(negedge clk) begin
        if (mem_rv) begin
            mem_rv = 1'b0;
        end else if (mem_req_any) begin
            if (mem_cnt <= 0) begin
                mem_rv = 1'b1;
                mem_rd = hw(mem_addr_any);
                mem_cnt = lat;
            end else mem_cnt--;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (done0 || done1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected completion", {31'h0, done1}, 32'h0);
            end else begin
                exp_t e;
                logic [31:0] ai, af;
                logic [1:0]  ac;
                e = exp_q.pop_front();
                ai = done1 ? insn1 : insn0;
                af = done1 ? fva1 : fva0;
                ac = done1 ? code1 : code0;
                chk(done1 == e.word_mode, e.req, "instance", {31'h0, done1}, {31'h0, e.word_mode});
                chk(ac == e.code, e.req, "fault code", {30'h0, ac}, {30'h0, e.code});
                chk(ai == e.insn, e.req, "instruction", ai, e.insn);
                if (e.code != 2'b00) chk(af == e.fva, e.req, "fault vaddr", af, e.fva);
                chk(nxl == e.nxl, e.req, "translation count", nxl, e.nxl);
            end
        end
    end

    task automatic fetch(bit wm, logic [31:0] a, int l, string req);
        @(negedge clk);
        while (!(wm ? ready1 : ready0)) @(negedge clk);
        lat = l; xl_cnt = l; mem_cnt = l; nxl = 0;
        exp_q.push_back(model(wm, a, req));
        va = a;
        if (wm) start1 = 1'b1; else start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0; start1 = 1'b0;
        while (!(wm ? done1 : done0)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ovr[32'h0003_5100] = 16'hABCF;  // va 0x2100, low bits 11
        ovr[32'h0003_6FFE] = 16'h1233;  // va 0x1FFE, last halfword of page
        ovr[32'h0003_5000] = 16'hBEEF;  // va 0x2000
        ovr[32'h0003_3FFE] = 16'h0003;  // va 0x4FFE, before faulting page
        ovr[32'h0003_5200] = 16'h7771;  // va 0x2200, low bits 01
        ovr[32'h0003_5202] = 16'h4444;
        ovr[32'h0003_5300] = 16'h1112;  // va 0x2300, low bits 10

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready0 && ready1, "R1", "ready in reset", {31'h0, ready0}, 32'h1);
        chk(!done0 && !done1, "R1", "done in reset", {31'h0, done0}, 32'h0);
        chk(!xreq0 && !mreq0 && !xreq1 && !mreq1, "R1", "requests in reset", {31'h0, xreq0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready0 && !done0, "R1", "idle after reset", {31'h0, ready0}, 32'h1);

        fetch(1'b0, 32'h0000_1001, 0, "R2");   // odd address
        fetch(1'b0, 32'h0000_1002, 1, "R3");   // bit 1 set is fine here
        fetch(1'b0, 32'h0000_1234, 0, "R4");   // low bits 00
        fetch(1'b0, 32'h0000_2200, 2, "R4");   // low bits 01
        fetch(1'b0, 32'h0000_2300, 0, "R4");   // low bits 10
        fetch(1'b0, 32'h0000_2100, 3, "R5");   // 32-bit inside page
        fetch(1'b0, 32'h0000_1FFE, 1, "R5");   // 32-bit across pages
        fetch(1'b0, 32'h0000_5010, 2, "R6");   // fault on low half
        fetch(1'b0, 32'h0000_4FFE, 0, "R6");   // fault on high half
        fetch(1'b1, 32'h0000_2100, 1, "R7");
        fetch(1'b1, 32'h0000_1234, 0, "R7");   // compressed-looking low bits ignored
        fetch(1'b1, 32'h0000_1232, 0, "R2");   // bit 1 misaligned in word mode
        fetch(1'b1, 32'h0000_5000, 2, "R6");

        // R8: start while busy is ignored
        @(negedge clk);
        lat = 3; xl_cnt = 3; mem_cnt = 3; nxl = 0;
        exp_q.push_back(model(1'b0, 32'h0000_2100, "R8"));
        va = 32'h0000_2100; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        chk(ready0 == 1'b0, "R8", "ready while busy", {31'h0, ready0}, 32'h0);
        va = 32'h0000_1001; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        while (!done0) @(negedge clk);
        chk(ready0 == 1'b0, "R8", "ready in done cycle", {31'h0, ready0}, 32'h0);
        @(negedge clk);
        chk(!done0 && ready0, "R8", "done single pulse", {31'h0, done0}, 32'h0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "pending items", exp_q.size(), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule